// File: doc/BRIEF.md
# Back-End Fast-Control Word Generator with Throttle Gating

The block produces one 44-bit fast-control word per bunch-crossing clock cycle for the back-end readout boards. Each word combines the running bunch number, a packet destination, trigger and calibration type codes and eight single-bit commands. The bunch number comes from an internal counter that wraps at a programmable orbit length. The commands are: trigger, crossing veto, full non-suppressed readout, header-only, back-end reset, front-end reset, event-number reset and bunch-number reset. All inputs sampled in a cycle appear together in the word one clock later.

Each connected readout board supplies one throttle line. While any throttle line is high, a crossing that would carry a trigger carries a reject instead, and a saturating counter records each such crossing. A small header-only sequencer holds the header-only flag high in two cases. After a non-suppressed readout crossing it covers a programmable gap of crossings. After a front-end reset it covers a programmable reset period. A vetoed crossing, taken from a per-crossing filling-scheme input, always carries header-only.

The sequencer has three states. `HS_IDLE` adds nothing to the header-only flag. `HS_NZS_GAP` counts the crossings after a non-suppressed readout. `HS_FE_RST` counts the front-end reset period. Its transitions are:
- `HS_IDLE`→`HS_NZS_GAP` on a readout request with a non-zero gap.
- `HS_NZS_GAP`→`HS_NZS_GAP` (counter reloaded) on a new readout request.
- `HS_NZS_GAP`→`HS_IDLE` and `HS_FE_RST`→`HS_IDLE` when the count runs out.
- any state→`HS_FE_RST` on a front-end reset request with a non-zero period.
- any state→`HS_IDLE` on a front-end reset request with a zero period.

Top module: `fcw_gen`

## Requirements
- R1: `word_out` is registered. The word present after clock edge k reflects the inputs sampled at edge k. Bits 43:32 hold the bunch number counted before that edge, bits 31:16 the destination, bits 15:12 the trigger type and bits 11:8 the calibration type.
- R2: The command bits sit at these positions: bit 7 trigger, bit 6 veto, bit 5 non-suppressed readout, bit 4 header-only, bit 3 back-end reset, bit 2 front-end reset, bit 1 event-number reset and bit 0 bunch-number reset. Each request appears only at its own position.
- R3: The bunch counter increments once per cycle. After reaching `cfg_bx_max` it returns to 0.
- R4: A bunch-number reset request sets bit 0 in its own word, and the next word carries bunch number 0.
- R5: While any bit of `throttle_in` is high, bit 7 is 0 whatever the trigger and calibration requests are.
- R6: `reject_cnt` increases by one for each crossing with a trigger or calibration request while throttled. It is unchanged otherwise and stops at its maximum value.
- R7: A vetoed crossing carries bits 6 and 4 set. The veto does not change the trigger bit.
- R8: After a non-suppressed readout crossing, the next `cfg_nzs_gap` words carry header-only. The readout crossing itself does not, unless something else sets it. A gap of 0 adds none.
- R9: A front-end reset crossing and the next `cfg_fe_len` words carry header-only.
- R10: A calibration request forces bit 7 (when not throttled) and puts `calib_type_in` in bits 11:8. Without a calibration request, bits 11:8 are 0.
- R11: During reset, `word_out` and `reject_cnt` are 0 and the bunch counter is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bunch-crossing clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_bx_max | input | 12 | last bunch number of an orbit |
| cfg_nzs_gap | input | GAP_W | header-only crossings after a readout crossing |
| cfg_fe_len | input | GAP_W | header-only crossings after a front-end reset |
| trig_in | input | 1 | trigger decision for this crossing |
| veto_in | input | 1 | filling-scheme veto for this crossing |
| dest_in | input | 16 | packet destination |
| trig_type_in | input | 4 | trigger type code |
| calib_req | input | 1 | calibration trigger request |
| calib_type_in | input | 4 | calibration type code |
| nzs_req | input | 1 | non-suppressed readout request |
| hdr_req | input | 1 | header-only request |
| be_rst_req | input | 1 | back-end reset request |
| fe_rst_req | input | 1 | front-end reset request |
| evid_rst_req | input | 1 | event-number reset request |
| bid_rst_req | input | 1 | bunch-number reset request |
| throttle_in | input | NUM_BOARDS | one throttle line per readout board |
| word_out | output | 44 | fast-control word |
| reject_cnt | output | REJ_W | throttled-trigger count |

## Verification
Field placement is tried with a run of changing destinations and type codes across two orbit wraps. This separates field swaps and counter wrap errors from correct packing. The trigger path is swept over every combination of trigger, calibration and all sixteen throttle patterns of a four-board setup. This distinguishes gating by any throttle line from gating by one line, and distinguishes calibration override from plain triggering. Single-command crossings, a vetoed trigger, and readout and front-end-reset runs with gap lengths of 3, 2 and 0 tell apart bit positions and off-by-one gap lengths. A long throttled burst shows that the count stops at its maximum rather than wrapping.

// File: rtl/fcw_pkg.sv
package fcw_pkg;
    localparam int BID_W  = 12;
    localparam int DEST_W = 16;
    localparam int TYPE_W = 4;
    localparam int WORD_W = BID_W + DEST_W + 2 * TYPE_W + 8;

    typedef struct packed {
        logic [BID_W-1:0]  bid;
        logic [DEST_W-1:0] dest;
        logic [TYPE_W-1:0] trig_type;
        logic [TYPE_W-1:0] calib_type;
        logic              trigger;
        logic              bx_veto;
        logic              nzs;
        logic              hdr_only;
        logic              be_rst;
        logic              fe_rst;
        logic              evid_rst;
        logic              bid_rst;
    } fcw_word_t;

    typedef enum logic [1:0] {
        HS_IDLE    = 2'd0,
        HS_NZS_GAP = 2'd1,
        HS_FE_RST  = 2'd2
    } hseq_state_e;
endpackage

// File: rtl/fcw_bx_counter.sv
module fcw_bx_counter
    import fcw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BID_W-1:0] cfg_bx_max,
    input  logic             clear_req,
    output logic [BID_W-1:0] bx_cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)                    bx_cnt <= '0;
        else if (clear_req)            bx_cnt <= '0;
        else if (bx_cnt >= cfg_bx_max) bx_cnt <= '0;
        else                           bx_cnt <= bx_cnt + 1'b1;
    end

    // R4
    bid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> (bx_cnt == '0));

    // R3
    bx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_req && bx_cnt < cfg_bx_max && $stable(cfg_bx_max))
        |=> (bx_cnt == $past(bx_cnt) + 1'b1));
endmodule

// File: rtl/fcw_hdr_seq.sv
module fcw_hdr_seq
    import fcw_pkg::*;
#(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nzs_req,
    input  logic             fe_rst_req,
    input  logic [GAP_W-1:0] cfg_nzs_gap,
    input  logic [GAP_W-1:0] cfg_fe_len,
    output logic             hold_hdr
);
    hseq_state_e      state_q, state_d;
    logic [GAP_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (fe_rst_req) begin
            if (cfg_fe_len != '0) begin
                state_d = HS_FE_RST;
                cnt_d   = cfg_fe_len;
            end else begin
                state_d = HS_IDLE;
                cnt_d   = '0;
            end
        end else begin
            unique case (state_q)
                HS_IDLE: begin
                    if (nzs_req && cfg_nzs_gap != '0) begin
                        state_d = HS_NZS_GAP;
                        cnt_d   = cfg_nzs_gap;
                    end
                end
                HS_NZS_GAP: begin
                    if (nzs_req) begin
                        if (cfg_nzs_gap != '0) begin
                            cnt_d = cfg_nzs_gap;
                        end else begin
                            state_d = HS_IDLE;
                            cnt_d   = '0;
                        end
                    end else if (cnt_q <= 1) begin
                        state_d = HS_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                HS_FE_RST: begin
                    if (cnt_q <= 1) begin
                        state_d = HS_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: begin
                    state_d = HS_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            HS_IDLE:    hold_hdr = 1'b0;
            HS_NZS_GAP: hold_hdr = 1'b1;
            HS_FE_RST:  hold_hdr = 1'b1;
            default:    hold_hdr = 1'b0;
        endcase
    end

    // R9
    fe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_rst_req && cfg_fe_len != '0) |=> (state_q == HS_FE_RST));

    // R8
    gap_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != HS_IDLE) |-> (cnt_q != '0));
endmodule

// File: rtl/fcw_thr_gate.sv
module fcw_thr_gate #(
    parameter int NUM_BOARDS = 8,
    parameter int REJ_W      = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fire,
    input  logic [NUM_BOARDS-1:0] throttle,
    output logic                  pass_trig,
    output logic [REJ_W-1:0]      reject_cnt
);
    localparam logic [REJ_W-1:0] REJ_MAX = '1;

    logic any_thr;
    logic rejecting;

    assign any_thr   = |throttle;
    assign rejecting = fire && any_thr;
    assign pass_trig = fire && !any_thr;

    always_ff @(posedge clk) begin
        if (!rst_n)                      reject_cnt <= '0;
        else if (rejecting && reject_cnt != REJ_MAX) reject_cnt <= reject_cnt + 1'b1;
    end

    // R6
    rej_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire && (|throttle)) |=> $stable(reject_cnt));

    // R6
    rej_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reject_cnt == REJ_MAX) |=> (reject_cnt == REJ_MAX));
endmodule

// File: rtl/fcw_gen.sv
module fcw_gen
    import fcw_pkg::*;
#(
    parameter int NUM_BOARDS = 8,
    parameter int REJ_W      = 32,
    parameter int GAP_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BID_W-1:0]      cfg_bx_max,
    input  logic [GAP_W-1:0]      cfg_nzs_gap,
    input  logic [GAP_W-1:0]      cfg_fe_len,
    input  logic                  trig_in,
    input  logic                  veto_in,
    input  logic [DEST_W-1:0]     dest_in,
    input  logic [TYPE_W-1:0]     trig_type_in,
    input  logic                  calib_req,
    input  logic [TYPE_W-1:0]     calib_type_in,
    input  logic                  nzs_req,
    input  logic                  hdr_req,
    input  logic                  be_rst_req,
    input  logic                  fe_rst_req,
    input  logic                  evid_rst_req,
    input  logic                  bid_rst_req,
    input  logic [NUM_BOARDS-1:0] throttle_in,
    output logic [WORD_W-1:0]     word_out,
    output logic [REJ_W-1:0]      reject_cnt
);
    logic [BID_W-1:0] bx_cnt;
    logic             hold_hdr;
    logic             pass_trig;
    fcw_word_t        word_d;

    fcw_bx_counter u_bx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_bx_max (cfg_bx_max),
        .clear_req  (bid_rst_req),
        .bx_cnt     (bx_cnt)
    );

    fcw_hdr_seq #(.GAP_W(GAP_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .nzs_req     (nzs_req),
        .fe_rst_req  (fe_rst_req),
        .cfg_nzs_gap (cfg_nzs_gap),
        .cfg_fe_len  (cfg_fe_len),
        .hold_hdr    (hold_hdr)
    );

    fcw_thr_gate #(.NUM_BOARDS(NUM_BOARDS), .REJ_W(REJ_W)) u_thr (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (trig_in | calib_req),
        .throttle   (throttle_in),
        .pass_trig  (pass_trig),
        .reject_cnt (reject_cnt)
    );

    always_comb begin
        word_d            = '0;
        word_d.bid        = bx_cnt;
        word_d.dest       = dest_in;
        word_d.trig_type  = trig_type_in;
        word_d.calib_type = calib_req ? calib_type_in : '0;
        word_d.trigger    = pass_trig;
        word_d.bx_veto    = veto_in;
        word_d.nzs        = nzs_req;
        word_d.hdr_only   = hdr_req | veto_in | fe_rst_req | hold_hdr;
        word_d.be_rst     = be_rst_req;
        word_d.fe_rst     = fe_rst_req;
        word_d.evid_rst   = evid_rst_req;
        word_d.bid_rst    = bid_rst_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) word_out <= '0;
        else        word_out <= word_d;
    end

    // R5
    thr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|throttle_in) |=> !word_out[7]);

    // R7
    veto_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        veto_in |=> (word_out[6] && word_out[4]));

    // R10
    calib_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (calib_req && !(|throttle_in)) |=> (word_out[7] && word_out[11:8] == $past(calib_type_in)));
endmodule

// File: tb/fcw_gen_tb.sv
module fcw_gen_tb;
    localparam int NB    = 4;
    localparam int RW    = 8;
    localparam int GW    = 4;
    localparam int RMAX  = (1 << RW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   cfg_bx_max = 12'd9;
    logic [GW-1:0] cfg_nzs_gap = 4'd3;
    logic [GW-1:0] cfg_fe_len = 4'd2;
    logic          trig_in = 0, veto_in = 0, calib_req = 0;
    logic [15:0]   dest_in = '0;
    logic [3:0]    trig_type_in = '0, calib_type_in = '0;
    logic          nzs_req = 0, hdr_req = 0, be_rst_req = 0;
    logic          fe_rst_req = 0, evid_rst_req = 0, bid_rst_req = 0;
    logic [NB-1:0] throttle_in = '0;
    logic [43:0]   word_out;
    logic [RW-1:0] reject_cnt;

    int checks = 0, errors = 0;
    int cur_bx = 0, last_bx = 0, exp_rej = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fcw_gen #(.NUM_BOARDS(NB), .REJ_W(RW), .GAP_W(GW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_bx_max(cfg_bx_max),
        .cfg_nzs_gap(cfg_nzs_gap), .cfg_fe_len(cfg_fe_len),
        .trig_in(trig_in), .veto_in(veto_in), .dest_in(dest_in),
        .trig_type_in(trig_type_in), .calib_req(calib_req),
        .calib_type_in(calib_type_in), .nzs_req(nzs_req), .hdr_req(hdr_req),
        .be_rst_req(be_rst_req), .fe_rst_req(fe_rst_req),
        .evid_rst_req(evid_rst_req), .bid_rst_req(bid_rst_req),
        .throttle_in(throttle_in), .word_out(word_out), .reject_cnt(reject_cnt)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        trig_in = 0; veto_in = 0; calib_req = 0; nzs_req = 0; hdr_req = 0;
        be_rst_req = 0; fe_rst_req = 0; evid_rst_req = 0; bid_rst_req = 0;
        throttle_in = '0; calib_type_in = '0;
    endtask

    task automatic step();
        last_bx = cur_bx;
        if (bid_rst_req) cur_bx = 0;
        else if (cur_bx >= int'(cfg_bx_max)) cur_bx = 0;
        else cur_bx = cur_bx + 1;
        if ((trig_in || calib_req) && (throttle_in != '0))
            exp_rej = (exp_rej == RMAX) ? RMAX : exp_rej + 1;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        check("R11 word", {20'd0, word_out}, 64'd0);
        check("R11 rejects", {56'd0, reject_cnt}, 64'd0);
        rst_n = 1'b1;

        // R1, R3: field placement across two orbit wraps
        for (int i = 0; i < 22; i++) begin
            dest_in = 16'(i * 4099 + 7);
            trig_type_in = 4'(i);
            step();
            check("R1 bid", {52'd0, word_out[43:32]}, 64'(last_bx));
            check("R1 dest", {48'd0, word_out[31:16]}, {48'd0, dest_in});
            check("R1 ttype", {60'd0, word_out[15:12]}, {60'd0, trig_type_in});
            check("R2 idle cmds", {56'd0, word_out[7:0]}, 64'd0);
        end
        // R3 wrap: 9 then 0
        while (cur_bx != 9) step();
        step();
        check("R3 top", {52'd0, word_out[43:32]}, 64'd9);
        step();
        check("R3 wrap", {52'd0, word_out[43:32]}, 64'd0);

        // R2 single commands
        be_rst_req = 1; step(); be_rst_req = 0;
        check("R2 be_rst", {56'd0, word_out[7:0]}, 64'h08);
        evid_rst_req = 1; step(); evid_rst_req = 0;
        check("R2 evid_rst", {56'd0, word_out[7:0]}, 64'h02);
        hdr_req = 1; step(); hdr_req = 0;
        check("R2 hdr", {56'd0, word_out[7:0]}, 64'h10);
        step(); step();
        bid_rst_req = 1; step(); bid_rst_req = 0;
        check("R4 bid_rst bit", {56'd0, word_out[7:0]}, 64'h01);
        step();
        check("R4 bid zero", {52'd0, word_out[43:32]}, 64'd0);
        step();
        check("R4 bid one", {52'd0, word_out[43:32]}, 64'd1);

        // R5, R6, R10 exhaustive trigger/calib/throttle
        for (int c = 0; c < 64; c++) begin
            trig_in = c[0];
            calib_req = c[1];
            throttle_in = 4'(c >> 2);
            calib_type_in = 4'(c) ^ 4'hA;
            step();
            check("R5 trigger", {63'd0, word_out[7]},
                  {63'd0, (c[0] | c[1]) && (c >> 2) == 0});
            check("R10 ctype", {60'd0, word_out[11:8]},
                  c[1] ? {60'd0, 4'(c) ^ 4'hA} : 64'd0);
            check("R6 count", {56'd0, reject_cnt}, 64'(exp_rej));
        end
        clear_in();

        // R7 veto with trigger
        veto_in = 1; trig_in = 1; step(); clear_in();
        check("R7 veto flags", {56'd0, word_out[7:0]}, 64'hD0);
        step();
        check("R7 veto released", {56'd0, word_out[7:0]}, 64'h00);

        // R8 readout gap of 3
        nzs_req = 1; step(); nzs_req = 0;
        check("R8 nzs crossing", {56'd0, word_out[7:0]}, 64'h20);
        for (int k = 0; k < 3; k++) begin
            step();
            check("R8 gap hdr", {56'd0, word_out[7:0]}, 64'h10);
        end
        step();
        check("R8 gap end", {56'd0, word_out[7:0]}, 64'h00);
        cfg_nzs_gap = '0;
        nzs_req = 1; step(); nzs_req = 0;
        check("R8 zero gap nzs", {56'd0, word_out[7:0]}, 64'h20);
        step();
        check("R8 zero gap none", {56'd0, word_out[7:0]}, 64'h00);

        // R9 front-end reset period of 2
        fe_rst_req = 1; step(); fe_rst_req = 0;
        check("R9 fe crossing", {56'd0, word_out[7:0]}, 64'h14);
        for (int k = 0; k < 2; k++) begin
            step();
            check("R9 fe hdr", {56'd0, word_out[7:0]}, 64'h10);
        end
        step();
        check("R9 fe end", {56'd0, word_out[7:0]}, 64'h00);

        // R6 saturation
        trig_in = 1; throttle_in = 4'b0100;
        for (int k = 0; k < 300; k++) step();
        check("R6 saturated", {56'd0, reject_cnt}, 64'(RMAX));
        step();
        check("R6 stays", {56'd0, reject_cnt}, 64'(RMAX));
        check("R5 throttled", {63'd0, word_out[7]}, 64'd0);
        clear_in();
        step();
        check("R6 idle hold", {56'd0, reject_cnt}, 64'(exp_rej));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule